// File: doc/BRIEF.md
# Memory Fence Ordering Controller

This block sits beside a core's load/store issue stage and decides, cycle by cycle, whether ordinary memory operations may issue. The core can have several loads and stores outstanding at once. It reports each load and store issue, and each completion, as a single-cycle pulse. The controller keeps a small in-flight count for each class. It also takes the store buffer's empty flag, so a store that has left the core but still sits in the buffer is not yet complete.

There are three kinds of ordering request. A fence waits for earlier loads, earlier stores, or both, depending on its kind. It then signals completion with a one-cycle done pulse, and holds back every later operation until that pulse. An acquire-tagged operation may issue while earlier work is still pending, but it closes the issue gate until its own completion pulse arrives. A release-tagged operation works the other way round: it is held back until everything earlier has drained, and it never closes the gate behind it. Only one fence or acquire may be pending at a time. Further requests are held off through ready outputs.

Top module: `mem_order_gate`

## Requirements
- R1: After reset, with the store buffer empty, `issue_ok`, `fence_ready`, `acq_ready` and `rel_ok` are 1, `fence_done` is 0, and no loads or stores are counted in flight.
- R2: Each in-flight counter is 4 bits wide. It rises by one on an issue pulse and falls by one on a completion pulse. When both pulses arrive in the same cycle, the count does not change.
- R3: A fence with `fence_kind` = 2'b01 (loads) completes on the first cycle with no load in flight, whatever the state of stores and the store buffer.
- R4: A fence with `fence_kind` = 2'b10 (stores) completes only on a cycle with no store in flight and `sb_empty` high, whatever loads are pending.
- R5: A fence with `fence_kind` = 2'b11 or 2'b00 (full) completes only when there are no loads in flight, no stores in flight, and `sb_empty` is high.
- R6: `fence_done` is a single-cycle pulse, raised on the first cycle after acceptance in which the fence's condition holds. A fence accepted with nothing outstanding therefore completes on the cycle after acceptance.
- R7: `issue_ok` is 0 from the cycle in which a fence is accepted up to and including the `fence_done` cycle, and returns to 1 on the next cycle if no new request arrives.
- R8: While a fence or acquire is pending, `fence_ready` and `acq_ready` are 0. When a fence and an acquire are requested in the same cycle, the fence wins and `acq_ready` is 0.
- R9: `issue_ok` is 0 from the cycle in which an acquire is accepted up to and including the cycle of its `acq_cmpl` pulse, and it is 1 on the following cycle.
- R10: `rel_ok` is 1 only when `issue_ok` is 1, no load or store is in flight, and `sb_empty` is 1.
- R11: An acquire is accepted whenever the controller is idle and no fence is requested, even with earlier loads or stores still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_issue | input | 1 | Pulse: one load issued |
| ld_done | input | 1 | Pulse: one load completed |
| st_issue | input | 1 | Pulse: one store issued |
| st_done | input | 1 | Pulse: one store left the core |
| sb_empty | input | 1 | Store buffer holds no stores |
| fence_valid | input | 1 | Fence request |
| fence_kind | input | 2 | 01 loads, 10 stores, 11 or 00 full |
| fence_ready | output | 1 | Fence request is accepted this cycle |
| acq_valid | input | 1 | Acquire-tagged operation wants to issue |
| acq_ready | output | 1 | Acquire is accepted this cycle |
| acq_cmpl | input | 1 | Pulse: the pending acquire completed |
| issue_ok | output | 1 | Ordinary operations may issue |
| rel_ok | output | 1 | Release-tagged operation may issue |
| fence_done | output | 1 | Pulse: the pending fence is complete |

## Verification
The assertions assume that the core never reports a completion without a matching earlier issue, never issues a fifteenth-plus-one operation of one class, and only pulses `acq_cmpl` while an acquire is pending. The overflow case is itself asserted as an input assumption. The directed stimulus keeps to these rules. Each scenario task pairs every completion pulse with an earlier issue, and loads the counters to at most fifteen. It then drives `acq_cmpl` only after an acquire has been accepted. Request signals are held for exactly one accepted cycle, so each fence or acquire is taken once.

// File: rtl/mog_pkg.sv
package mog_pkg;
  localparam int CNT_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FENCE = 2'd1,
    ST_ACQ   = 2'd2
  } mog_state_e;

  typedef enum logic [1:0] {
    FK_FULL_ALT = 2'b00,
    FK_LOADS    = 2'b01,
    FK_STORES   = 2'b10,
    FK_FULL     = 2'b11
  } fence_kind_e;
endpackage

// File: rtl/mog_flight_ctr.sv
module mog_flight_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         zero
);
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  // Register enable: change only when exactly one pulse is present.
  always_comb begin
    cnt_en = inc ^ dec;
    cnt_d  = cnt;
    if (inc && !dec) cnt_d = cnt + W'(1);
    else if (dec && !inc) cnt_d = cnt - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/mog_seq.sv
module mog_seq
  import mog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fence_acc,
  input  logic [1:0]  kind_in,
  input  logic        acq_acc,
  input  logic        acq_cmpl,
  input  logic        loads_clear,
  input  logic        stores_clear,
  output mog_state_e  state,
  output logic [1:0]  kind_q,
  output logic        fence_done
);
  mog_state_e state_d;
  logic       kind_en;
  logic       cond_met;

  // Wait condition of the pending fence, from its latched kind.
  always_comb begin
    unique case (kind_q)
      FK_LOADS:  cond_met = loads_clear;
      FK_STORES: cond_met = stores_clear;
      default:   cond_met = loads_clear && stores_clear;
    endcase
  end

  assign fence_done = (state == ST_FENCE) && cond_met;
  assign kind_en    = fence_acc;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: begin
        if (fence_acc)    state_d = ST_FENCE;
        else if (acq_acc) state_d = ST_ACQ;
      end
      ST_FENCE: if (cond_met) state_d = ST_IDLE;
      ST_ACQ:   if (acq_cmpl) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       kind_q <= FK_FULL;
    else if (kind_en) kind_q <= kind_in;
  end
endmodule

// File: rtl/mem_order_gate.sv
module mem_order_gate
  import mog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_issue,
  input  logic       ld_done,
  input  logic       st_issue,
  input  logic       st_done,
  input  logic       sb_empty,
  input  logic       fence_valid,
  input  logic [1:0] fence_kind,
  output logic       fence_ready,
  input  logic       acq_valid,
  output logic       acq_ready,
  input  logic       acq_cmpl,
  output logic       issue_ok,
  output logic       rel_ok,
  output logic       fence_done
);
  localparam int NCLS = 2;  // class 0: loads, class 1: stores

  logic             rst_meta, rst_q;
  logic [NCLS-1:0]  inc_v, dec_v, zero_v;
  logic [CNT_W-1:0] cnt_v [NCLS];
  logic [CNT_W-1:0] ld_cnt, st_cnt;
  logic             loads_clear, stores_clear;
  logic             fence_acc, acq_acc, idle;
  logic [1:0]       kind_q;
  mog_state_e       state;

  // Reset asserts at once, leaves after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  assign inc_v = {st_issue, ld_issue};
  assign dec_v = {st_done,  ld_done};

  for (genvar g = 0; g < NCLS; g++) begin : g_ctr
    mog_flight_ctr #(.W(CNT_W)) u_ctr (
      .clk  (clk),
      .rst_n(rst_q),
      .inc  (inc_v[g]),
      .dec  (dec_v[g]),
      .cnt  (cnt_v[g]),
      .zero (zero_v[g])
    );
  end

  assign ld_cnt       = cnt_v[0];
  assign st_cnt       = cnt_v[1];
  assign loads_clear  = zero_v[0];
  assign stores_clear = zero_v[1] && sb_empty;

  assign idle        = (state == ST_IDLE);
  assign fence_ready = idle;
  assign acq_ready   = idle && !fence_valid;
  assign fence_acc   = fence_valid && fence_ready;
  assign acq_acc     = acq_valid && acq_ready;

  mog_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_q),
    .fence_acc   (fence_acc),
    .kind_in     (fence_kind),
    .acq_acc     (acq_acc),
    .acq_cmpl    (acq_cmpl),
    .loads_clear (loads_clear),
    .stores_clear(stores_clear),
    .state       (state),
    .kind_q      (kind_q),
    .fence_done  (fence_done)
  );

  assign issue_ok = idle && !fence_acc && !acq_acc;
  assign rel_ok   = issue_ok && loads_clear && stores_clear;
endmodule

// File: rtl/mog_checker.sv
module mog_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ld_issue,
  input logic       ld_done,
  input logic       sb_empty,
  input logic       fence_valid,
  input logic       fence_ready,
  input logic       acq_valid,
  input logic       acq_ready,
  input logic       issue_ok,
  input logic       rel_ok,
  input logic       fence_done,
  input logic [3:0] ld_cnt,
  input logic [3:0] st_cnt,
  input logic [1:0] kind_q
);
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_cnt == 4'hF && ld_issue && !ld_done));

  p_ld_fence_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_done && kind_q == 2'b01) |-> (ld_cnt == 4'd0));

  p_st_fence_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_done && kind_q == 2'b10) |-> (st_cnt == 4'd0 && sb_empty));

  p_full_fence_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_done && (kind_q == 2'b11 || kind_q == 2'b00)) |->
      (ld_cnt == 4'd0 && st_cnt == 4'd0 && sb_empty));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fence_done |=> !fence_done);

  p_accept_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_valid && fence_ready) |-> !issue_ok);

  p_done_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fence_done |-> !issue_ok);

  p_reopen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fence_done |=> fence_ready);

  p_one_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fence_ready |-> !acq_ready);

  p_acq_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_valid && acq_ready) |=> !issue_ok);

  p_rel_drained_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rel_ok |-> (issue_ok && sb_empty && ld_cnt == 4'd0 && st_cnt == 4'd0));
endmodule

bind mem_order_gate mog_checker u_mog_checker (
  .clk        (clk),
  .rst_n      (rst_q),
  .ld_issue   (ld_issue),
  .ld_done    (ld_done),
  .sb_empty   (sb_empty),
  .fence_valid(fence_valid),
  .fence_ready(fence_ready),
  .acq_valid  (acq_valid),
  .acq_ready  (acq_ready),
  .issue_ok   (issue_ok),
  .rel_ok     (rel_ok),
  .fence_done (fence_done),
  .ld_cnt     (ld_cnt),
  .st_cnt     (st_cnt),
  .kind_q     (kind_q)
);

// File: tb/test_mem_order_gate.sv
module test_mem_order_gate;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ld_issue, ld_done, st_issue, st_done, sb_empty;
  logic       fence_valid, acq_valid, acq_cmpl;
  logic [1:0] fence_kind;
  logic       fence_ready, acq_ready, issue_ok, rel_ok, fence_done;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  mem_order_gate i_mem_order_gate (
    .clk(clk), .rst_n(rst_n),
    .ld_issue(ld_issue), .ld_done(ld_done),
    .st_issue(st_issue), .st_done(st_done), .sb_empty(sb_empty),
    .fence_valid(fence_valid), .fence_kind(fence_kind), .fence_ready(fence_ready),
    .acq_valid(acq_valid), .acq_ready(acq_ready), .acq_cmpl(acq_cmpl),
    .issue_ok(issue_ok), .rel_ok(rel_ok), .fence_done(fence_done)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Advance one clock; outputs are read 2 ns after the edge.
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic pulse(input logic li, input logic ld, input logic si, input logic sd);
    ld_issue = li; ld_done = ld; st_issue = si; st_done = sd;
    step();
    ld_issue = 0; ld_done = 0; st_issue = 0; st_done = 0;
    #1;
  endtask

  // Present a fence for one accepted cycle; check the gate closes in it.
  task automatic send_fence(input logic [1:0] k, input string tag);
    fence_valid = 1; fence_kind = k;
    #1;
    check({tag, " R7 gate closed on acceptance"}, issue_ok, 1'b0);
    step();
    fence_valid = 0;
    #1;
  endtask

  task automatic t_reset();
    check("R1 issue_ok", issue_ok, 1'b1);
    check("R1 fence_ready", fence_ready, 1'b1);
    check("R1 acq_ready", acq_ready, 1'b1);
    check("R1 rel_ok", rel_ok, 1'b1);
    check("R1 fence_done", fence_done, 1'b0);
  endtask

  task automatic t_load_fence();
    pulse(1, 0, 0, 0);
    pulse(1, 0, 0, 0);
    sb_empty = 0;
    pulse(0, 0, 1, 0);
    send_fence(2'b01, "R3");
    check("R3 waiting with loads pending", fence_done, 1'b0);
    check("R8 fence_ready low while pending", fence_ready, 1'b0);
    check("R8 acq_ready low while pending", acq_ready, 1'b0);
    pulse(0, 1, 0, 0);
    check("R3 one load left", fence_done, 1'b0);
    pulse(0, 1, 0, 0);
    check("R3 done with store still pending", fence_done, 1'b1);
    check("R7 gate closed in done cycle", issue_ok, 1'b0);
    step();
    check("R6 single-cycle pulse", fence_done, 1'b0);
    check("R7 gate reopens", issue_ok, 1'b1);
  endtask

  task automatic t_store_fence();
    // One store still in flight, buffer not empty; add a load pending.
    pulse(1, 0, 0, 0);
    send_fence(2'b10, "R4");
    check("R4 waiting on store", fence_done, 1'b0);
    pulse(0, 0, 0, 1);
    check("R4 buffer not empty", fence_done, 1'b0);
    sb_empty = 1;
    #1;
    check("R4 done with load still pending", fence_done, 1'b1);
    step();
    check("R6 pulse ends", fence_done, 1'b0);
    check("R10 rel_ok low with load pending", rel_ok, 1'b0);
    pulse(0, 1, 0, 0);
    check("R10 rel_ok when drained", rel_ok, 1'b1);
  endtask

  task automatic t_full_fence();
    pulse(1, 0, 1, 0);
    sb_empty = 0;
    send_fence(2'b11, "R5");
    pulse(0, 1, 0, 0);
    check("R5 store still pending", fence_done, 1'b0);
    pulse(0, 0, 0, 1);
    check("R5 buffer still full", fence_done, 1'b0);
    sb_empty = 1;
    #1;
    check("R5 done when all drained", fence_done, 1'b1);
    step();
    send_fence(2'b00, "R5 alt");
    check("R6 idle fence done on next cycle", fence_done, 1'b1);
    step();
    check("R6 alt pulse ends", fence_done, 1'b0);
  endtask

  task automatic t_counters();
    pulse(1, 0, 0, 0);
    pulse(1, 1, 0, 0);
    send_fence(2'b01, "R2");
    check("R2 simultaneous pulses keep count", fence_done, 1'b0);
    pulse(0, 1, 0, 0);
    check("R2 done after last load", fence_done, 1'b1);
    step();
    for (int i = 0; i < 15; i++) pulse(1, 0, 0, 0);
    send_fence(2'b01, "R2 deep");
    for (int i = 0; i < 14; i++) pulse(0, 1, 0, 0);
    check("R2 fifteen loads: one still pending", fence_done, 1'b0);
    pulse(0, 1, 0, 0);
    check("R2 fifteen loads drained", fence_done, 1'b1);
    step();
  endtask

  task automatic t_acquire();
    pulse(1, 0, 0, 0);
    acq_valid = 1;
    #1;
    check("R11 acquire accepted with load pending", acq_ready, 1'b1);
    step();
    acq_valid = 0;
    #1;
    check("R9 gate closed after acquire", issue_ok, 1'b0);
    check("R8 fence_ready low during acquire", fence_ready, 1'b0);
    pulse(0, 1, 0, 0);
    check("R9 still closed after earlier load", issue_ok, 1'b0);
    acq_cmpl = 1;
    #1;
    check("R9 closed in completion cycle", issue_ok, 1'b0);
    step();
    acq_cmpl = 0;
    #1;
    check("R9 reopens after completion", issue_ok, 1'b1);
  endtask

  task automatic t_priority_release();
    fence_valid = 1; fence_kind = 2'b11; acq_valid = 1;
    #1;
    check("R8 fence wins over acquire", acq_ready, 1'b0);
    check("R10 rel_ok low on fence acceptance", rel_ok, 1'b0);
    step();
    fence_valid = 0; acq_valid = 0;
    #1;
    check("R5 idle full fence done", fence_done, 1'b1);
    step();
    sb_empty = 0;
    #1;
    check("R10 rel_ok low with buffer busy", rel_ok, 1'b0);
    check("R10 ordinary ops still allowed", issue_ok, 1'b1);
    sb_empty = 1;
    #1;
    check("R10 rel_ok restored", rel_ok, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    ld_issue = 0; ld_done = 0; st_issue = 0; st_done = 0; sb_empty = 1;
    fence_valid = 0; fence_kind = 2'b11; acq_valid = 0; acq_cmpl = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (3) step();
    t_reset();
    t_load_fence();
    t_store_fence();
    t_full_fence();
    t_counters();
    t_acquire();
    t_priority_release();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule